// File: doc/BRIEF.md
# Lookup-Table Clock-Enable Divider with Stop Control

This block turns a free-running parent clock into a periodic one-cycle enable pulse. Downstream logic uses the pulse to advance at a reduced rate. A single control register holds two fields. A 4-bit selector chooses the divide ratio from a fixed table of non-power-of-two values that has gaps in it. A stop bit holds the enable low while it is 1.

Software writes the register through a simple write strobe and reads it back at any time. Selector codes that have no divisor are rejected, and the previously accepted code stays in force. A new divisor is applied only at the end of the period in progress, so a shortened period is never produced. Releasing the stop bit always starts a complete fresh period.

Top module: `tbl_clk_div`

## Requirements
- R1: After reset the register reads 0x0101 (selector code 1, stop bit set) and `clk_en_o` stays low.
- R2: The selector sits in register bits 3:0 and the stop bit in bit 8. All other bits are ignored on write and read as 0. Every write loads the stop bit from write-data bit 8.
- R3: Selector codes map to divide ratios as 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48. The selector that reads back is always one of these codes.
- R4: A write carrying selector code 0, 9, 12, 13, 14 or 15 leaves the stored selector and the active ratio unchanged. The stop bit is still updated.
- R5: While the stop bit is 1, `clk_en_o` is 0 and the period counter is held at its start.
- R6: Suppose the stop bit is cleared by a write, and cycle 0 is the cycle following that write's clock edge. The first pulse then appears in cycle N-1, where N is the selected ratio.
- R7: While running, `clk_en_o` is high for exactly one parent cycle in every N cycles.
- R8: A selector change written while running takes effect only after the current period completes, so no interval between pulses is shorter than the old period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W (16) | Register write data |
| reg_rdata_o | output | DATA_W (16) | Register read data |
| clk_en_o | output | 1 | Divided one-cycle enable pulse |

## Verification
The hardest situation to reach is a ratio change landing in the middle of a long period, because the old and new ratios must both be visible in successive pulse intervals. The bench starts the 48 ratio and writes ratio 3 a few cycles into the first period. It then checks that the pulse still arrives at cycle 47 and that the 3-cycle spacing begins only after it. A second directed case stops the output in mid-period and releases it, to prove that the restart discards the partial count.

// File: rtl/tbl_clk_div_pkg.sv
package tbl_clk_div_pkg;
  localparam int SEL_W = 4;
  localparam int DIV_W = 6;

  typedef struct packed {
    logic             ok;
    logic [DIV_W-1:0] div;
  } div_entry_t;

  function automatic div_entry_t div_lookup(input logic [SEL_W-1:0] code);
    div_entry_t e;
    e.ok = 1'b1;
    unique case (code)
      4'd1:    e.div = 6'd3;
      4'd2:    e.div = 6'd4;
      4'd3:    e.div = 6'd6;
      4'd4:    e.div = 6'd8;
      4'd5:    e.div = 6'd12;
      4'd6:    e.div = 6'd16;
      4'd7:    e.div = 6'd18;
      4'd8:    e.div = 6'd24;
      4'd10:   e.div = 6'd36;
      4'd11:   e.div = 6'd48;
      default: begin e.ok = 1'b0; e.div = 6'd0; end
    endcase
    return e;
  endfunction
endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import tbl_clk_div_pkg::*;
(
  input  logic [SEL_W-1:0] code_i,
  output logic             ok_o,
  output logic [DIV_W-1:0] div_o
);
  div_entry_t ent;
  always_comb begin
    ent   = div_lookup(code_i);
    ok_o  = ent.ok;
    div_o = ent.div;
  end
endmodule

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg
  import tbl_clk_div_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SEL_LSB  = 0,
  parameter int GATE_BIT = 8,
  parameter logic [SEL_W-1:0] RST_SEL = 4'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              stop_o
);
  logic [SEL_W-1:0] sel_q;
  logic             stop_q;
  logic [SEL_W-1:0] wr_code;
  logic             wr_ok;
  logic [DIV_W-1:0] wr_div_unused;

  assign wr_code = wdata_i[SEL_LSB +: SEL_W];

  clkdiv_decode u_wr_dec (
    .code_i(wr_code),
    .ok_o  (wr_ok),
    .div_o (wr_div_unused)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= RST_SEL;
      stop_q <= 1'b1;
    end else if (we_i) begin
      stop_q <= wdata_i[GATE_BIT];
      if (wr_ok) sel_q <= wr_code;  // unmapped codes rejected
    end
  end

  always_comb begin
    rdata_o                     = '0;
    rdata_o[SEL_LSB +: SEL_W]   = sel_q;
    rdata_o[GATE_BIT]           = stop_q;
  end

  assign sel_o  = sel_q;
  assign stop_o = stop_q;
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import tbl_clk_div_pkg::*;
#(
  parameter logic [DIV_W-1:0] RST_DIV = 6'd3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic [DIV_W-1:0] pend_div_i,
  output logic             en_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cur_q;
  logic             armed_q;
  logic [DIV_W-1:0] eff_div;
  logic             hit;

  // first running cycle uses the pending ratio directly
  assign eff_div = armed_q ? cur_q : pend_div_i;
  assign hit     = !stop_i && (cnt_q == eff_div - DIV_W'(1));
  assign en_o    = hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cur_q   <= RST_DIV;
      armed_q <= 1'b0;
    end else if (stop_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (hit) begin
        cnt_q <= '0;
        cur_q <= pend_div_i;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
        if (!armed_q) cur_q <= pend_div_i;
      end
    end
  end
endmodule

// File: rtl/tbl_clk_div.sv
module tbl_clk_div
  import tbl_clk_div_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SEL_LSB  = 0,
  parameter int GATE_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              clk_en_o
);
  localparam logic [SEL_W-1:0] RST_SEL = 4'd1;
  localparam div_entry_t       RST_ENT = div_lookup(RST_SEL);

  logic [SEL_W-1:0] sel;
  logic             stop;
  logic             sel_ok_unused;
  logic [DIV_W-1:0] pend_div;

  clkdiv_ctrl_reg #(
    .DATA_W  (DATA_W),
    .SEL_LSB (SEL_LSB),
    .GATE_BIT(GATE_BIT),
    .RST_SEL (RST_SEL)
  ) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .sel_o  (sel),
    .stop_o (stop)
  );

  clkdiv_decode u_cur_dec (
    .code_i(sel),
    .ok_o  (sel_ok_unused),
    .div_o (pend_div)
  );

  clkdiv_counter #(
    .RST_DIV(RST_ENT.div)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stop_i    (stop),
    .pend_div_i(pend_div),
    .en_o      (clk_en_o)
  );
endmodule

// File: rtl/tbl_clk_div_checker.sv
module tbl_clk_div_checker
  import tbl_clk_div_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SEL_LSB  = 0,
  parameter int GATE_BIT = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              clk_en_o
);
  logic [5:0] gap_q;
  logic       stopped;
  assign stopped = reg_rdata_o[GATE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               gap_q <= '0;
    else if (stopped || clk_en_o) gap_q <= '0;
    else if (gap_q != 6'h3f)   gap_q <= gap_q + 6'd1;
  end

  assert_stop_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped |-> !clk_en_o);

  assert_pulse_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |=> !clk_en_o);

  assert_no_short_period_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> gap_q >= 6'd2);

  assert_unmapped_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !div_lookup(reg_wdata_i[SEL_LSB +: SEL_W]).ok)
      |=> reg_rdata_o[SEL_LSB +: SEL_W] == $past(reg_rdata_o[SEL_LSB +: SEL_W]));

  assert_stop_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o[GATE_BIT] == $past(reg_wdata_i[GATE_BIT]));

  assert_sel_mapped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_lookup(reg_rdata_o[SEL_LSB +: SEL_W]).ok);
endmodule

bind tbl_clk_div tbl_clk_div_checker #(
  .DATA_W(DATA_W), .SEL_LSB(SEL_LSB), .GATE_BIT(GATE_BIT)
) u_chk (.*);

// File: tb/tbl_clk_div_bench.sv
module tbl_clk_div_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        en;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tbl_clk_div u_tbl_clk_div (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .clk_en_o(en)
  );

  // {code written, expected readback code, expected ratio}
  localparam logic [15:0] VEC [17] = '{
    {4'd1, 4'd1, 8'd3},   {4'd2, 4'd2, 8'd4},   {4'd3, 4'd3, 8'd6},
    {4'd4, 4'd4, 8'd8},   {4'd5, 4'd5, 8'd12},  {4'd6, 4'd6, 8'd16},
    {4'd7, 4'd7, 8'd18},  {4'd8, 4'd8, 8'd24},  {4'd10, 4'd10, 8'd36},
    {4'd11, 4'd11, 8'd48}, {4'd0, 4'd11, 8'd48}, {4'd9, 4'd11, 8'd48},
    {4'd12, 4'd11, 8'd48}, {4'd15, 4'd11, 8'd48}, {4'd1, 4'd1, 8'd3},
    {4'd13, 4'd1, 8'd3},  {4'd14, 4'd1, 8'd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns at a negedge, cycle 0 after the write edge
  task automatic wr(input logic [15:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  // sample from current negedge (cycle 0); record first two pulse cycles
  task automatic watch(input int ncyc, output int p1, output int p2, output int np);
    p1 = -1; p2 = -1; np = 0;
    for (int n = 0; n < ncyc; n++) begin
      if (en) begin
        if (np == 0) p1 = n; else if (np == 1) p2 = n;
        np++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int p1, p2, np;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset readback", rdata, 16'h0101);
    watch(20, p1, p2, np);
    chk("R1 no pulse after reset", np, 0);

    // table walk: R3 mapping, R4 unmapped, R6 restart, R7 period
    foreach (VEC[i]) begin
      int code = VEC[i][15:12];
      int expc = VEC[i][11:8];
      int div  = VEC[i][7:0];
      wr(16'h0100 | 16'(code));
      chk("R4/R3 readback", rdata, 16'h0100 | 16'(expc));
      wr(16'(expc));
      watch(2 * div + 2, p1, p2, np);
      chk("R6 first pulse", p1, div - 1);
      chk("R3/R7 period", p2 - p1, div);
      wr(16'h0100);
    end

    // R2 unused bits ignored, bit 8 clear opens
    wr(16'hFEF1);
    chk("R2 readback masks", rdata, 16'h0001);
    watch(8, p1, p2, np);
    chk("R2 running ratio 3", p1, 2);
    // R4 unmapped code still updates stop bit
    wr(16'h010C);
    chk("R4 stop updated with bad code", rdata, 16'h0101);

    // R5 stop mid-period, then R6 full restart
    wr(16'h010B);
    wr(16'h000B);
    repeat (20) @(negedge clk);
    wr(16'h010B);
    watch(60, p1, p2, np);
    chk("R5 quiet while stopped", np, 0);
    wr(16'h000B);
    watch(50, p1, p2, np);
    chk("R6 full period after release", p1, 47);

    // R8 change mid-period takes effect at boundary
    wr(16'h010B);
    wr(16'h000B);
    begin
      int pulses[3];
      int k = 0;
      for (int n = 0; n < 60; n++) begin
        if (n == 5) begin we = 1'b1; wdata = 16'h0001; end
        if (n == 6) we = 1'b0;
        if (en && k < 3) begin pulses[k] = n; k++; end
        @(negedge clk);
      end
      chk("R8 old period honoured", pulses[0], 47);
      chk("R8 new ratio after boundary", pulses[1], 50);
      chk("R8 new ratio steady", pulses[2], 53);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule